// File: doc/BRIEF.md
# Fractional Clock Divider with Triggered Update

This block turns a fast input clock into a clock-enable pulse stream whose average rate is the input rate divided by a programmable divisor with fractional bits. It keeps a phase accumulator. Each enabled input cycle adds one unit (2^FRAC_WIDTH in scaled terms). When the sum reaches the active scaled divisor, the divisor is subtracted and one enable pulse is produced. Downstream logic uses the pulse as a qualified clock enable.

Software controls the block through one 32-bit control word. The write port has a per-bit mask. The word holds a divisor field, a gate-enable bit and a trigger bit. The divisor field stores the scaled divisor minus one unit, so a field value of zero means divide-by-one. A newly written field stays in the shadow word until software writes 1 to the trigger bit. The pending update is applied at the next output pulse, and only while the gate is enabled. The trigger bit clears itself in that same cycle. A build parameter can fix the divisor at a constant, which makes the field read-only.

Top module: `frac_clkdiv_trig`

## Requirements
- R1: After reset the control word reads 0x0000_0000, `clk_en_o` is low, and the active divisor is the minimum. Enabling the gate (bit 0) with no trigger therefore gives a pulse on every input cycle.
- R2: The scaled divisor is D = field + 2^FRAC_WIDTH. The field sits at bits [FIELD_SHIFT+DIV_WIDTH-1:FIELD_SHIFT], which is bits [15:8] by default. Over any N·D consecutive input cycles that follow an applied update, exactly N·2^FRAC_WIDTH pulses are produced.
- R3: An all-ones field gives the largest divisor, 2^DIV_WIDTH − 1 + 2^FRAC_WIDTH, and it obeys the same pulse count rule.
- R4: A write changes only the bits whose mask bit is 1. All other bits of the control word keep their value.
- R5: Writing the field without a trigger leaves the output rate unchanged.
- R6: Writing 1 to the trigger bit (bit 31) makes it read 1 from the next cycle. It reads 1 until the update is applied, and then clears in the same cycle as an output pulse. Writing 0 to the trigger bit does not cancel a pending update.
- R7: While the gate bit is 0, `clk_en_o` stays low and a pending trigger stays pending.
- R8: With FIXED_MODE=1, the field reads back as FIXED_SCALED − 2^FRAC_WIDTH. Field writes are ignored, and the rate is set by FIXED_SCALED alone.
- R9: When D is a multiple of 2^FRAC_WIDTH, pulses are spaced exactly D/2^FRAC_WIDTH cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_mask | input | 32 | Per-bit write enable |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Control word readback, with the trigger bit showing the pending state |
| clk_en_o | output | 1 | Divided clock-enable pulse, registered |

## Verification
The divider is run with an integer divisor, with quarter- and half-step fractional divisors, with divide-by-one and with the all-ones field. The pulse count over a whole number of divisor periods tells a wrong offset in the field from a wrong accumulator step or a wrong subtraction. An alternation check at divide-by-two catches uneven spacing, which a count alone would miss. Directed sequences show that a shadow write without a trigger, and a trigger while the gate is off, change nothing, and show that a fixed build ignores the field.

// File: rtl/frac_div_pkg.sv
// Package: shared constants and helpers for the fractional clock divider.
// Assumes a 32-bit control word.
package frac_div_pkg;
    localparam int REG_W = 32;

    // Builds a mask that covers a field of the given width at the given shift.
    function automatic logic [REG_W-1:0] field_mask(input int shift, input int width);
        logic [63:0] m;
        m = ((64'd1 << width) - 64'd1) << shift;
        return m[REG_W-1:0];
    endfunction
endpackage

// File: rtl/fdiv_ctrl_reg.sv
// Module: control word with masked writes and a self-clearing trigger.
// Holds the shadow divisor field and the gate bit. In fixed mode the field
// reads back as a constant and cannot be written. The trigger bit reads as
// the pending flag. Assumes the field, gate and trigger bits do not overlap.
module fdiv_ctrl_reg
    import frac_div_pkg::*;
#(
    parameter int DIV_WIDTH    = 8,
    parameter int FRAC_WIDTH   = 2,
    parameter int FIELD_SHIFT  = 8,
    parameter int GATE_BIT     = 0,
    parameter int TRIG_BIT     = 31,
    parameter bit FIXED_MODE   = 1'b0,
    parameter int FIXED_SCALED = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_mask,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 load_done,
    output logic [REG_W-1:0]     rd_data,
    output logic [DIV_WIDTH-1:0] field_o,
    output logic                 gate_o,
    output logic                 pend_o
);
    localparam logic [REG_W-1:0] FMASK    = field_mask(FIELD_SHIFT, DIV_WIDTH);
    localparam logic [REG_W-1:0] TMASK    = field_mask(TRIG_BIT, 1);
    localparam logic [REG_W-1:0] WRITABLE = FIXED_MODE ? ~(FMASK | TMASK) : ~TMASK;
    localparam logic [DIV_WIDTH-1:0] FIX_FIELD =
        DIV_WIDTH'(FIXED_SCALED - (2 ** FRAC_WIDTH));

    logic [REG_W-1:0] word_q;
    logic [REG_W-1:0] wmask_eff;
    logic             trig_set;

    assign wmask_eff = wr_en ? (wr_mask & WRITABLE) : '0;
    assign trig_set  = wr_en & wr_mask[TRIG_BIT] & wr_data[TRIG_BIT];

    // Updates the stored bits named by the effective write mask.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= (word_q & ~wmask_eff) | (wr_data & wmask_eff);
    end

    // Pending flag: set by a trigger write, cleared when the load is applied.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_o <= 1'b0;
        else if (trig_set)  pend_o <= 1'b1;
        else if (load_done) pend_o <= 1'b0;
    end

    // Builds the readback word, with the fixed field and the pending flag.
    always_comb begin
        rd_data = word_q;
        if (FIXED_MODE)
            rd_data[FIELD_SHIFT +: DIV_WIDTH] = FIX_FIELD;
        rd_data[TRIG_BIT] = pend_o;
    end

    assign field_o = rd_data[FIELD_SHIFT +: DIV_WIDTH];
    assign gate_o  = word_q[GATE_BIT];

    // R6: a trigger write is visible as pending in the next cycle.
    a_r6_trig_sets: assert property (@(posedge clk) disable iff (!rst_n)
        trig_set |=> pend_o);
    // R4: the gate bit does not move when its mask bit is clear.
    a_r4_gate_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_mask[GATE_BIT]) |=> $stable(gate_o));
endmodule

// File: rtl/fdiv_accum.sv
// Module: fractional phase accumulator that holds the active divisor.
// Adds 2^FRAC_WIDTH on each gated cycle. When the sum reaches the active
// scaled divisor, it subtracts the divisor and registers a pulse. A pending
// update is loaded on a pulse cycle. Assumes FIXED_SCALED lies in
// [2^FRAC_WIDTH, 2^DIV_WIDTH-1+2^FRAC_WIDTH].
module fdiv_accum #(
    parameter int DIV_WIDTH    = 8,
    parameter int FRAC_WIDTH   = 2,
    parameter bit FIXED_MODE   = 1'b0,
    parameter int FIXED_SCALED = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gate_i,
    input  logic                 pend_i,
    input  logic [DIV_WIDTH-1:0] field_i,
    output logic                 clk_en_o,
    output logic                 load_o
);
    localparam int ACC_W = ((DIV_WIDTH > FRAC_WIDTH) ? DIV_WIDTH : FRAC_WIDTH) + 2;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(2 ** FRAC_WIDTH);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] div_q;
    logic [ACC_W-1:0] sum;
    logic             hit;

    assign sum    = acc_q + STEP;
    assign hit    = (sum >= div_q);
    assign load_o = gate_i & hit & pend_i;

    // Advances the phase and registers the output pulse while the gate is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            clk_en_o <= 1'b0;
        end else if (gate_i) begin
            clk_en_o <= hit;
            acc_q    <= hit ? (sum - div_q) : sum;
        end else begin
            clk_en_o <= 1'b0;
        end
    end

    generate
        if (FIXED_MODE) begin : g_fixed
            assign div_q = ACC_W'(FIXED_SCALED);
            logic unused_field;
            assign unused_field = ^field_i;
            // R8: the active divisor is the build constant.
            a_r8_fixed_div: assert property (@(posedge clk) disable iff (!rst_n)
                div_q == ACC_W'(FIXED_SCALED));
        end else begin : g_prog
            // Loads field plus one unit into the active divisor at the boundary.
            always_ff @(posedge clk) begin
                if (!rst_n)      div_q <= STEP;
                else if (load_o) div_q <= ACC_W'(field_i) + STEP;
            end
            // R5: with nothing pending, the active divisor holds.
            a_r5_div_holds: assert property (@(posedge clk) disable iff (!rst_n)
                !pend_i |=> $stable(div_q));
        end
    endgenerate

    // R2: the phase stays below the active divisor.
    a_r2_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < div_q);
    // R2: the active divisor is never below one unit.
    a_r2_div_min: assert property (@(posedge clk) disable iff (!rst_n)
        div_q >= STEP);
    // R7: no pulse follows a cycle with the gate off.
    a_r7_gated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i |=> !clk_en_o);
    // R6: a load happens only together with a pulse.
    a_r6_load_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> clk_en_o);
endmodule

// File: rtl/frac_clkdiv_trig.sv
// Module: top of the fractional clock divider with a triggered update.
// Connects the control word to the accumulator. The output is a registered
// clock-enable pulse in the input clock domain.
module frac_clkdiv_trig
    import frac_div_pkg::*;
#(
    parameter int DIV_WIDTH    = 8,
    parameter int FRAC_WIDTH   = 2,
    parameter int FIELD_SHIFT  = 8,
    parameter int GATE_BIT     = 0,
    parameter int TRIG_BIT     = 31,
    parameter bit FIXED_MODE   = 1'b0,
    parameter int FIXED_SCALED = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_mask,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    output logic        clk_en_o
);
    logic [DIV_WIDTH-1:0] field;
    logic                 gate;
    logic                 pend;
    logic                 load;

    fdiv_ctrl_reg #(
        .DIV_WIDTH(DIV_WIDTH), .FRAC_WIDTH(FRAC_WIDTH), .FIELD_SHIFT(FIELD_SHIFT),
        .GATE_BIT(GATE_BIT), .TRIG_BIT(TRIG_BIT), .FIXED_MODE(FIXED_MODE),
        .FIXED_SCALED(FIXED_SCALED)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_mask(reg_wr_mask),
        .wr_data(reg_wr_data), .load_done(load), .rd_data(reg_rd_data),
        .field_o(field), .gate_o(gate), .pend_o(pend)
    );

    fdiv_accum #(
        .DIV_WIDTH(DIV_WIDTH), .FRAC_WIDTH(FRAC_WIDTH), .FIXED_MODE(FIXED_MODE),
        .FIXED_SCALED(FIXED_SCALED)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .gate_i(gate), .pend_i(pend), .field_i(field),
        .clk_en_o(clk_en_o), .load_o(load)
    );
endmodule

// File: tb/frac_clkdiv_trig_bench.sv
module frac_clkdiv_trig_bench;
    localparam int NV = 7;
    localparam logic [7:0] VEC_FIELD  [NV] = '{8'h00, 8'h01, 8'h02, 8'h06, 8'h0C, 8'h05, 8'hFF};
    localparam int         VEC_WIN    [NV] = '{2, 1, 3, 1, 2, 1, 1};
    localparam int         VEC_PULSES [NV] = '{8, 4, 12, 4, 8, 4, 4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, fwr_en = 1'b0;
    logic [31:0] wr_mask = '0, wr_data = '0, fwr_mask = '0, fwr_data = '0;
    logic [31:0] rd, frd;
    logic        en, fen;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    frac_clkdiv_trig u_frac_clkdiv_trig (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_mask(wr_mask),
        .reg_wr_data(wr_data), .reg_rd_data(rd), .clk_en_o(en));

    frac_clkdiv_trig #(.FIXED_MODE(1'b1), .FIXED_SCALED(10)) u_frac_clkdiv_trig_fixed (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(fwr_en), .reg_wr_mask(fwr_mask),
        .reg_wr_data(fwr_data), .reg_rd_data(frd), .clk_en_o(fen));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] m, input logic [31:0] d);
        wr_en = 1'b1; wr_mask = m; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fwr(input logic [31:0] m, input logic [31:0] d);
        fwr_en = 1'b1; fwr_mask = m; fwr_data = d;
        @(negedge clk);
        fwr_en = 1'b0;
    endtask

    task automatic count_pulses(input bit fixed, input int cycles, output int cnt);
        cnt = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (fixed ? fen : en) cnt++;
        end
    endtask

    task automatic wait_clear(input bit fixed, input string tag);
        int k = 0;
        while (((fixed ? frd[31] : rd[31]) == 1'b1) && k < 1000) begin
            @(negedge clk);
            k++;
        end
        chk(tag, 32'(fixed ? frd[31] : rd[31]), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int cnt;
        logic prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset word", rd, 32'h0);
        chk("R1 reset clk_en", 32'(en), 32'd0);
        chk("R8 fixed reset word", frd, 32'h0000_0600);

        // R1: gate on with the minimum divisor gives a pulse every cycle
        wr(32'h1, 32'h1);
        count_pulses(1'b0, 8, cnt);
        chk("R1 divide-by-one", 32'(cnt), 32'd8);

        // R2/R3: table of fields, each counted over whole divisor periods
        for (int i = 0; i < NV; i++) begin
            int d;
            d = int'(VEC_FIELD[i]) + 4;
            wr(32'h0000_FF00, {16'h0, VEC_FIELD[i], 8'h0});
            chk("R2 field readback", rd, {16'h0, VEC_FIELD[i], 8'h01});
            wr(32'h8000_0000, 32'h8000_0000);
            chk("R6 trigger pending", 32'(rd[31]), 32'd1);
            wait_clear(1'b0, "R6 trigger self-clear");
            count_pulses(1'b0, VEC_WIN[i] * d, cnt);
            chk((VEC_FIELD[i] == 8'hFF) ? "R3 max divisor pulses" : "R2 pulse count",
                32'(cnt), 32'(VEC_PULSES[i]));
        end

        // R9: divide-by-two alternates exactly
        wr(32'h0000_FF00, 32'h0000_0400);
        wr(32'h8000_0000, 32'h8000_0000);
        wait_clear(1'b0, "R6 trigger self-clear d2");
        @(negedge clk);
        prev = en;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            chk("R9 even spacing", 32'(en), 32'(!prev));
            prev = en;
        end

        // R5: a shadow write without a trigger keeps the rate
        wr(32'h0000_FF00, 32'h0000_1C00);
        count_pulses(1'b0, 8, cnt);
        chk("R5 rate kept", 32'(cnt), 32'd4);

        // R7: gate off, trigger stays pending, no pulses
        wr(32'h1, 32'h0);
        @(negedge clk);
        wr(32'h8000_0000, 32'h8000_0000);
        count_pulses(1'b0, 20, cnt);
        chk("R7 gated no pulses", 32'(cnt), 32'd0);
        chk("R7 pending kept", 32'(rd[31]), 32'd1);
        wr(32'h8000_0000, 32'h0);
        chk("R6 zero write no cancel", 32'(rd[31]), 32'd1);
        wr(32'h1, 32'h1);
        wait_clear(1'b0, "R6 clear after gate on");
        count_pulses(1'b0, 32, cnt);
        chk("R2 d=32 pulses", 32'(cnt), 32'd4);

        // R4: masked writes keep the other bits
        wr(32'h0000_00F0, 32'hFFFF_FFFF);
        chk("R4 mask low nibble", rd, 32'h0000_1CF1);
        wr(32'h0000_FF00, 32'h0000_0300);
        chk("R4 mask field only", rd, 32'h0000_03F1);

        // R8: fixed build ignores field writes and keeps its rate
        fwr(32'h0000_FF01, 32'h0000_0001);
        chk("R8 fixed field ignored", frd, 32'h0000_0601);
        count_pulses(1'b1, 10, cnt);
        chk("R8 fixed rate", 32'(cnt), 32'd4);
        fwr(32'h8000_0000, 32'h8000_0000);
        chk("R8 fixed trigger pending", 32'(frd[31]), 32'd1);
        wait_clear(1'b1, "R8 fixed trigger clear");
        count_pulses(1'b1, 20, cnt);
        chk("R8 fixed rate after trigger", 32'(cnt), 32'd8);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule